// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block is the fetch front end of a five-stage in-order pipeline. It owns the program counter and the register between fetch and decode. It presents a fetch address to instruction memory and captures the returned word, together with the word's address, into a decode-stage register that carries a valid tag. Decode resolves each conditional branch while the branch sits in that register and returns three signals in the same cycle: a branch flag, the outcome and the target. The controller then steers fetch according to a static branch policy.

Three policies are supported.
- **Freeze** always spends one idle fetch slot on a branch. The fetch that follows the branch is repeated once the outcome is known.
- **Speculative sequential fetch** keeps fetching down the fall-through path. When the branch is taken, the wrongly fetched successor is dropped as a bubble.
- **Single delay slot** always lets the successor run and redirects fetch right after it.

The policy input is sampled continuously. It must be held constant whenever reset is not asserted.

Top module: `bhz_fetch_ctl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `imem_addr_o` equals `RESET_VEC` and `id_valid_o` is 0.
- R2: In a cycle with no valid branch in decode, the next cycle holds the fetched word and its address in decode with `id_valid_o`=1, and `imem_addr_o` advances by `PC_STEP` (4).
- R3: Freeze policy (`mode_i`=2'b00), untaken branch: the next cycle shows `id_valid_o`=0, and `imem_addr_o` keeps the same address so that the successor is fetched again.
- R4: Freeze policy, taken branch: the next cycle shows `id_valid_o`=0 and `imem_addr_o` equal to the target.
- R5: Speculative sequential policy (`mode_i`=2'b01), untaken branch: no penalty. The successor enters decode valid, and fetch advances by `PC_STEP`.
- R6: Speculative sequential policy, taken branch: the successor enters decode with `id_valid_o`=0, and `imem_addr_o` equals the target in the next cycle.
- R7: Delay-slot policy (`mode_i`=2'b10): the successor always enters decode valid. The next fetch address is the target if the branch is taken, otherwise the sequential address.
- R8: `dec_branch_i`, `dec_taken_i` and `dec_target_i` have no effect while `id_valid_o` is 0, so fetch proceeds sequentially.
- R9: The encoding `mode_i`=2'b11 behaves exactly like the freeze policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Branch policy: 00 freeze, 01 speculative sequential, 10 delay slot, 11 freeze |
| imem_addr_o | output | ADDR_W | Fetch address (program counter) |
| imem_data_i | input | INSTR_W | Instruction word at `imem_addr_o`, same cycle |
| dec_branch_i | input | 1 | Decode flags the word in decode as a conditional branch |
| dec_taken_i | input | 1 | Resolved branch outcome |
| dec_target_i | input | ADDR_W | Resolved branch target |
| id_instr_o | output | INSTR_W | Instruction word held for decode |
| id_pc_o | output | ADDR_W | Address of the word held for decode |
| id_valid_o | output | 1 | Decode entry is live; 0 means a bubble |

## Verification
A random instruction stream with dense, often back-to-back branches is run under every policy. The bench targets the following errors:
- A freeze controller that advances the program counter would skip the instruction after an untaken branch.
- A speculative controller that fails to squash would let a wrong-path word reach decode as valid.
- A delay-slot controller that inserts a bubble would lose the slot instruction.

While decode holds a bubble, the branch inputs are driven with random junk. A controller that does not gate them with the valid tag would redirect fetch to a garbage target. The spare mode encoding is exercised separately, to catch a decoder that treats it as one of the zero-penalty policies.

// File: rtl/bhz_pkg.sv
package bhz_pkg;
  typedef enum logic [1:0] {
    POL_FREEZE = 2'b00,
    POL_SPEC   = 2'b01,
    POL_DELAY  = 2'b10,
    POL_SPARE  = 2'b11
  } policy_e;

  typedef struct packed {
    logic kill;      // drop the word fetched this cycle
    logic redirect;  // load target into pc
    logic hold;      // keep pc (refetch)
  } fetch_ctl_t;
endpackage

// File: rtl/bhz_policy_ctl.sv
module bhz_policy_ctl
  import bhz_pkg::*;
(
  input  logic       [1:0] mode_i,
  input  logic             br_i,
  input  logic             taken_i,
  output fetch_ctl_t       ctl_o
);
  policy_e pol;
  assign pol = policy_e'(mode_i);

  always_comb begin
    ctl_o = '0;
    case (pol)
      POL_SPEC: begin
        ctl_o.kill     = br_i & taken_i;
        ctl_o.redirect = br_i & taken_i;
      end
      POL_DELAY: begin
        ctl_o.redirect = br_i & taken_i;
      end
      default: begin // freeze and spare encoding
        ctl_o.kill     = br_i;
        ctl_o.redirect = br_i & taken_i;
        ctl_o.hold     = br_i & ~taken_i;
      end
    endcase
  end
endmodule

// File: rtl/bhz_pc_gen.sv
module bhz_pc_gen #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000,
  parameter int unsigned       PC_STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] StepV = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] pc_q, pc_d;

  always_comb begin
    if (redirect_i)  pc_d = target_i;
    else if (hold_i) pc_d = pc_q;
    else             pc_d = pc_q + StepV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_VEC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/bhz_ifid_reg.sv
module bhz_ifid_reg #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               kill_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic               valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_o <= '0;
      pc_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      // a squash only drops the tag; payload bits load regardless
      instr_o <= instr_i;
      pc_o    <= pc_i;
      valid_o <= ~kill_i;
    end
  end
endmodule

// File: rtl/bhz_fetch_ctl.sv
module bhz_fetch_ctl
  import bhz_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       INSTR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000,
  parameter int unsigned       PC_STEP   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  input  logic               dec_branch_i,
  input  logic               dec_taken_i,
  input  logic [ADDR_W-1:0]  dec_target_i,
  output logic [INSTR_W-1:0] id_instr_o,
  output logic [ADDR_W-1:0]  id_pc_o,
  output logic               id_valid_o
);
  fetch_ctl_t ctl;
  logic       br_in_id;

  // decode inputs only count when the decode entry is live
  assign br_in_id = id_valid_o & dec_branch_i;

  bhz_policy_ctl u_policy (
    .mode_i  (mode_i),
    .br_i    (br_in_id),
    .taken_i (dec_taken_i),
    .ctl_o   (ctl)
  );

  bhz_pc_gen #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC),
    .PC_STEP   (PC_STEP)
  ) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (ctl.hold),
    .redirect_i (ctl.redirect),
    .target_i   (dec_target_i),
    .pc_o       (imem_addr_o)
  );

  bhz_ifid_reg #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
  ) u_ifid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kill_i  (ctl.kill),
    .instr_i (imem_data_i),
    .pc_i    (imem_addr_o),
    .instr_o (id_instr_o),
    .pc_o    (id_pc_o),
    .valid_o (id_valid_o)
  );
endmodule

// File: rtl/bhz_fetch_ctl_chk.sv
module bhz_fetch_ctl_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000,
  parameter int unsigned       PC_STEP   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic              dec_branch_i,
  input logic              dec_taken_i,
  input logic [ADDR_W-1:0] dec_target_i,
  input logic [ADDR_W-1:0] id_pc_o,
  input logic              id_valid_o
);
  localparam logic [ADDR_W-1:0] StepV = ADDR_W'(PC_STEP);

  logic br, frz;
  assign br  = id_valid_o & dec_branch_i;
  assign frz = (mode_i == 2'b00) || (mode_i == 2'b11);

  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (imem_addr_o == RESET_VEC) && !id_valid_o);

  a_r2_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br |=> id_valid_o && (id_pc_o == $past(imem_addr_o))
            && (imem_addr_o == $past(imem_addr_o) + StepV));

  a_r3_freeze_untaken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz && br && !dec_taken_i) |=> !id_valid_o && (imem_addr_o == $past(imem_addr_o)));

  a_r4_freeze_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz && br && dec_taken_i) |=> !id_valid_o && (imem_addr_o == $past(dec_target_i)));

  a_r5_spec_untaken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && br && !dec_taken_i) |=>
      id_valid_o && (imem_addr_o == $past(imem_addr_o) + StepV));

  a_r6_spec_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && br && dec_taken_i) |=>
      !id_valid_o && (imem_addr_o == $past(dec_target_i)));

  a_r7_delay_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && br) |=> id_valid_o && (imem_addr_o ==
      ($past(dec_taken_i) ? $past(dec_target_i) : $past(imem_addr_o) + StepV)));

  a_r8_bubble_ignores_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_o |=> id_valid_o && (imem_addr_o == $past(imem_addr_o) + StepV));

  a_r9_spare_is_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && br) |=> !id_valid_o);
endmodule

bind bhz_fetch_ctl bhz_fetch_ctl_chk #(
  .ADDR_W    (ADDR_W),
  .RESET_VEC (RESET_VEC),
  .PC_STEP   (PC_STEP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .imem_addr_o  (imem_addr_o),
  .dec_branch_i (dec_branch_i),
  .dec_taken_i  (dec_taken_i),
  .dec_target_i (dec_target_i),
  .id_pc_o      (id_pc_o),
  .id_valid_o   (id_valid_o)
);

// File: tb/tb_bhz_fetch_ctl.sv
module tb_bhz_fetch_ctl;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [31:0] imem_addr_o, imem_data_i, dec_target_i, id_instr_o, id_pc_o;
  logic        dec_branch_i, dec_taken_i, id_valid_o;

  logic        junk_br = 1'b0, junk_tk = 1'b0;
  logic [31:0] junk_tgt = '0;
  logic [31:0] salt = 32'h5a5a_0f0f;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [31:0] s);
    logic [31:0] x;
    x = (a * 32'h9E37_79B1) ^ s;
    return {x[18:0], x[31:19]};
  endfunction
  function automatic logic is_br(input logic [31:0] w); return w[1:0] == 2'b11; endfunction
  function automatic logic is_tk(input logic [31:0] w); return w[2]; endfunction
  function automatic logic [31:0] tgt_of(input logic [31:0] w);
    return {20'h0, w[13:4], 2'b00};
  endfunction

  // behavioral instruction memory and decode stage
  assign imem_data_i  = mem_word(imem_addr_o, salt);
  assign dec_branch_i = id_valid_o ? is_br(id_instr_o)  : junk_br;
  assign dec_taken_i  = id_valid_o ? is_tk(id_instr_o)  : junk_tk;
  assign dec_target_i = id_valid_o ? tgt_of(id_instr_o) : junk_tgt;

  bhz_fetch_ctl #(.RESET_VEC(RV)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
    .dec_branch_i(dec_branch_i), .dec_taken_i(dec_taken_i), .dec_target_i(dec_target_i),
    .id_instr_o(id_instr_o), .id_pc_o(id_pc_o), .id_valid_o(id_valid_o)
  );

  logic [31:0] e_pc, e_instr, e_ipc;
  logic        e_valid;

  task automatic check(input string tag);
    bit bad;
    n_run++;
    bad = (imem_addr_o !== e_pc) || (id_valid_o !== e_valid) ||
          (e_valid && ((id_instr_o !== e_instr) || (id_pc_o !== e_ipc)));
    if (bad) begin
      n_fail++;
      $display("FAIL %s mode=%0d: addr=%h valid=%b instr=%h pc=%h, expected addr=%h valid=%b instr=%h pc=%h",
               tag, mode_i, imem_addr_o, id_valid_o, id_instr_o, id_pc_o,
               e_pc, e_valid, e_instr, e_ipc);
    end
  endtask

  task automatic run_mode(input logic [1:0] m, input int cycles);
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_i = m;
    salt   = $urandom;
    junk_br = 1'b1; junk_tk = 1'b1; junk_tgt = 32'hdead_0000;
    e_pc = RV; e_valid = 1'b0; e_instr = '0; e_ipc = '0;
    #1 check("R1 in reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check("R1 after release");
    for (int i = 0; i < cycles; i++) begin
      logic        br, tk, kill;
      logic [31:0] nxt, fetched;
      string       tag;
      // R8 directed: junk decode inputs during every bubble, often claiming a taken branch
      junk_br  = ($urandom % 4) != 0;
      junk_tk  = $urandom % 2;
      junk_tgt = {$urandom} & 32'h0000_fffc;
      br = e_valid && is_br(e_instr);
      tk = is_tk(e_instr);
      fetched = mem_word(e_pc, salt);
      case (m)
        2'b01: begin kill = br & tk; nxt = (br & tk) ? tgt_of(e_instr) : e_pc + 4; end
        2'b10: begin kill = 1'b0;    nxt = (br & tk) ? tgt_of(e_instr) : e_pc + 4; end
        default: begin
          kill = br;
          nxt  = br ? (tk ? tgt_of(e_instr) : e_pc) : e_pc + 4;
        end
      endcase
      if (br) begin
        case (m)
          2'b00:   tag = tk ? "R4 freeze taken" : "R3 freeze untaken";
          2'b01:   tag = tk ? "R6 spec taken"   : "R5 spec untaken";
          2'b10:   tag = "R7 delay slot";
          default: tag = "R9 spare as freeze";
        endcase
      end else if (!e_valid && junk_br) tag = "R8 bubble ignores decode";
      else tag = "R2 sequential";
      e_instr = fetched; e_ipc = e_pc; e_valid = !kill; e_pc = nxt;
      @(negedge clk_i);
      check(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_mode(2'b00, 400);
    run_mode(2'b01, 400);
    run_mode(2'b10, 400);
    run_mode(2'b11, 300);
    // mid-stream reset returns to the vector
    run_mode(2'b01, 20);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule